// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the effective address of a memory-format instruction: loads, stores and register-indirect branches. It takes the low 24 bits of the first instruction word, the optional 32-bit displacement word that follows it, the address of the instruction and the values read from two register-file ports (base and index). It returns the register numbers those ports must read, and one cycle after a request it returns the address and an illegal-encoding flag.

A word with bit 12 clear uses the short form: a 12-bit unsigned offset, optionally added to the base register. A word with bit 12 set uses the long form, where bits 13:10 pick one of seven address kinds: base only, instruction-relative, base plus scaled index, displacement only, displacement plus base, displacement plus scaled index, and all three together. The decoder classifies every word into one of these kinds. It has two short-form kinds (`AK_OFF`, `AK_OFF_BASE`), the seven long-form kinds (`AK_BASE`, `AK_IPREL`, `AK_BASE_IDX`, `AK_DISP`, `AK_DISP_BASE`, `AK_DISP_IDX`, `AK_DISP_BASE_IDX`) and `AK_ILLEGAL`.

The result register has two states. It loads when `in_valid` is high and holds otherwise.

Top module: `eff_addr_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `ea_bad` and `ea_out` are all 0.
- R2: `base_sel` equals instruction bits 18:14, `index_sel` equals bits 4:0 and `data_sel` equals bits 23:19, combinationally in the same cycle.
- R3: `out_valid` is high in the cycle after a cycle with `in_valid` high, and is low otherwise. While `in_valid` is low, `ea_out` and `ea_bad` keep their values.
- R4: When bit 12 is clear, the address is bits 11:0, zero-extended, plus `base_val` when bit 13 is set. Such a word is never flagged illegal, whatever bits 9:5 hold.
- R5: Long mode 4 (bits 13:10 = 4'b0100) gives `base_val`. Mode 5 gives `disp_word + 8 + instr_addr`.
- R6: Mode 7 gives `base_val + (index_val << s)`, where s is the scale code in bits 9:7. Codes 0 to 4 multiply by 1, 2, 4, 8 and 16.
- R7: Mode 12 gives `disp_word`. Mode 13 gives `disp_word + base_val`.
- R8: Mode 14 gives `disp_word + (index_val << s)`. Mode 15 gives `disp_word + base_val + (index_val << s)`.
- R9: In the long form, a scale code of 5, 6 or 7 marks the word illegal, in every long mode.
- R10: In the long form, a nonzero value in bits 6:5 marks the word illegal, and so does mode 6.
- R11: When the word is illegal, `ea_bad` is 1 and `ea_out` is 0.
- R12: All sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request: capture a result this cycle |
| instr_word | input | 24 | Bits 23:0 of the first instruction word |
| disp_word | input | 32 | Displacement word (long form) |
| instr_addr | input | 32 | Address of the instruction |
| base_val | input | 32 | Value read at `base_sel` |
| index_val | input | 32 | Value read at `index_sel` |
| base_sel | output | 5 | Base register number |
| index_sel | output | 5 | Index register number |
| data_sel | output | 5 | Data register number |
| out_valid | output | 1 | Result valid |
| ea_out | output | 32 | Effective address |
| ea_bad | output | 1 | Illegal encoding |

## Verification
The hardest case to reach is an encoding that is illegal only through a field the selected mode never uses. Examples are a bad scale code under a displacement-only mode, or nonzero bits 6:5 under base-only mode. Random words seldom land on these, so the bench builds each one from field values, with a nonzero base, index and displacement. If the illegal path were ignored, `ea_out` would then be nonzero. Short-form words that carry an out-of-range scale pattern in their offset bits are applied as well, to show that the checks stay confined to the long form.

// File: rtl/eag_pkg.sv
package eag_pkg;
    typedef enum logic [3:0] {
        AK_OFF,
        AK_OFF_BASE,
        AK_BASE,
        AK_IPREL,
        AK_BASE_IDX,
        AK_DISP,
        AK_DISP_BASE,
        AK_DISP_IDX,
        AK_DISP_BASE_IDX,
        AK_ILLEGAL
    } addr_kind_t;

    typedef struct packed {
        logic use_off;
        logic use_disp;
        logic use_base;
        logic use_idx;
        logic use_ip;
    } terms_t;
endpackage

// File: rtl/eag_decode.sv
module eag_decode
    import eag_pkg::*;
#(
    parameter int SCALE_W   = 3,
    parameter int MAX_SCALE = 4
) (
    input  logic [13:5]        mode_bits,
    output addr_kind_t         kind,
    output terms_t             terms,
    output logic [SCALE_W-1:0] scale_code
);
    logic [3:0] mode;
    logic       long_form;
    logic       field_bad;

    assign mode       = mode_bits[13:10];
    assign long_form  = mode[2];
    assign scale_code = mode_bits[9:7];
    assign field_bad  = (int'(scale_code) > MAX_SCALE) || (mode_bits[6:5] != 2'b00);

    always_comb begin
        if (!long_form) begin
            kind = mode[3] ? AK_OFF_BASE : AK_OFF;
        end else if (field_bad) begin
            kind = AK_ILLEGAL;
        end else begin
            unique case (mode)
                4'd4:    kind = AK_BASE;
                4'd5:    kind = AK_IPREL;
                4'd7:    kind = AK_BASE_IDX;
                4'd12:   kind = AK_DISP;
                4'd13:   kind = AK_DISP_BASE;
                4'd14:   kind = AK_DISP_IDX;
                4'd15:   kind = AK_DISP_BASE_IDX;
                default: kind = AK_ILLEGAL;
            endcase
        end
    end

    always_comb begin
        terms = '0;
        unique case (kind)
            AK_OFF:           terms.use_off = 1'b1;
            AK_OFF_BASE:      begin terms.use_off = 1'b1; terms.use_base = 1'b1; end
            AK_BASE:          terms.use_base = 1'b1;
            AK_IPREL:         begin terms.use_disp = 1'b1; terms.use_ip = 1'b1; end
            AK_BASE_IDX:      begin terms.use_base = 1'b1; terms.use_idx = 1'b1; end
            AK_DISP:          terms.use_disp = 1'b1;
            AK_DISP_BASE:     begin terms.use_disp = 1'b1; terms.use_base = 1'b1; end
            AK_DISP_IDX:      begin terms.use_disp = 1'b1; terms.use_idx = 1'b1; end
            AK_DISP_BASE_IDX: begin
                terms.use_disp = 1'b1; terms.use_base = 1'b1; terms.use_idx = 1'b1;
            end
            default:          terms = '0;
        endcase
    end

    // R4
    short_never_bad_chk: assert final (long_form || kind != AK_ILLEGAL);
endmodule

// File: rtl/eag_scale.sv
module eag_scale #(
    parameter int AW        = 32,
    parameter int SCALE_W   = 3,
    parameter int MAX_SCALE = 4
) (
    input  logic [AW-1:0]      index_val,
    input  logic [SCALE_W-1:0] scale_code,
    output logic [AW-1:0]      scaled
);
    localparam int NCAND = MAX_SCALE + 1;

    logic [AW-1:0] cand [NCAND];

    for (genvar k = 0; k < NCAND; k++) begin : g_shift
        assign cand[k] = index_val << k;
    end

    always_comb begin
        scaled = '0;
        for (int k = 0; k < NCAND; k++) begin
            if (int'(scale_code) == k) scaled = cand[k];
        end
    end
endmodule

// File: rtl/eag_sum.sv
module eag_sum
    import eag_pkg::*;
#(
    parameter int AW      = 32,
    parameter int OFF_W   = 12,
    parameter int IP_BIAS = 8
) (
    input  terms_t            terms,
    input  logic [OFF_W-1:0]  offset,
    input  logic [AW-1:0]     disp_word,
    input  logic [AW-1:0]     instr_addr,
    input  logic [AW-1:0]     base_val,
    input  logic [AW-1:0]     scaled_idx,
    output logic [AW-1:0]     addr
);
    logic [AW-1:0] t_lead;
    logic [AW-1:0] t_base;
    logic [AW-1:0] t_idx;
    logic [AW-1:0] t_ip;

    always_comb begin
        t_lead = terms.use_off  ? AW'(offset) : (terms.use_disp ? disp_word : '0);
        t_base = terms.use_base ? base_val   : '0;
        t_idx  = terms.use_idx  ? scaled_idx : '0;
        t_ip   = terms.use_ip   ? instr_addr + AW'(IP_BIAS) : '0;
        addr   = t_lead + t_base + t_idx + t_ip;
    end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eag_pkg::*;
#(
    parameter int AW        = 32,
    parameter int RIDX_W    = 5,
    parameter int SCALE_W   = 3,
    parameter int MAX_SCALE = 4,
    parameter int IP_BIAS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [23:0]       instr_word,
    input  logic [AW-1:0]     disp_word,
    input  logic [AW-1:0]     instr_addr,
    input  logic [AW-1:0]     base_val,
    input  logic [AW-1:0]     index_val,
    output logic [RIDX_W-1:0] base_sel,
    output logic [RIDX_W-1:0] index_sel,
    output logic [RIDX_W-1:0] data_sel,
    output logic              out_valid,
    output logic [AW-1:0]     ea_out,
    output logic              ea_bad
);
    localparam int OFF_W = 12;

    addr_kind_t         kind;
    terms_t             terms;
    logic [SCALE_W-1:0] scale_code;
    logic [AW-1:0]      scaled_idx;
    logic [AW-1:0]      addr_c;
    logic               bad_c;

    assign base_sel  = instr_word[14 +: RIDX_W];
    assign index_sel = instr_word[0 +: RIDX_W];
    assign data_sel  = instr_word[19 +: RIDX_W];

    eag_decode #(.SCALE_W(SCALE_W), .MAX_SCALE(MAX_SCALE)) u_decode (
        .mode_bits  (instr_word[13:5]),
        .kind       (kind),
        .terms      (terms),
        .scale_code (scale_code)
    );

    eag_scale #(.AW(AW), .SCALE_W(SCALE_W), .MAX_SCALE(MAX_SCALE)) u_scale (
        .index_val  (index_val),
        .scale_code (scale_code),
        .scaled     (scaled_idx)
    );

    eag_sum #(.AW(AW), .OFF_W(OFF_W), .IP_BIAS(IP_BIAS)) u_sum (
        .terms      (terms),
        .offset     (instr_word[OFF_W-1:0]),
        .disp_word  (disp_word),
        .instr_addr (instr_addr),
        .base_val   (base_val),
        .scaled_idx (scaled_idx),
        .addr       (addr_c)
    );

    assign bad_c = (kind == AK_ILLEGAL);

    // result register: valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // result register: address and flag, loaded on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_out <= '0;
            ea_bad <= 1'b0;
        end else if (in_valid) begin
            ea_out <= bad_c ? '0 : addr_c;
            ea_bad <= bad_c;
        end
    end

    // R3
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R3
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(ea_out) && $stable(ea_bad)));
    // R11
    bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ea_bad |-> (ea_out == '0));
    // R10
    mode6_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr_word[13:10] == 4'd6) |=> ea_bad);
    // R4
    short_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr_word[12]) |=> !ea_bad);
endmodule

// File: tb/tb_eff_addr_gen.sv
module tb_eff_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] instr_word = '0;
    logic [31:0] disp_word = '0;
    logic [31:0] instr_addr = '0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic [4:0]  base_sel, index_sel, data_sel;
    logic        out_valid, ea_bad;
    logic [31:0] ea_out;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    eff_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr_word(instr_word),
        .disp_word(disp_word), .instr_addr(instr_addr), .base_val(base_val),
        .index_val(index_val), .base_sel(base_sel), .index_sel(index_sel),
        .data_sel(data_sel), .out_valid(out_valid), .ea_out(ea_out), .ea_bad(ea_bad)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] long_w(input logic [4:0] d, input logic [4:0] b,
            input logic [3:0] m, input logic [2:0] s, input logic [1:0] z, input logic [4:0] x);
        return {d, b, m, s, z, x};
    endfunction

    function automatic logic [23:0] short_w(input logic [4:0] d, input logic [4:0] b,
            input logic use_b, input logic [11:0] off);
        return {d, b, use_b, 1'b0, off};
    endfunction

    // apply one request and check result one cycle later
    task automatic run(input string tag, input logic [23:0] w, input logic [31:0] dsp,
            input logic [31:0] ip, input logic [31:0] bv, input logic [31:0] iv,
            input logic [31:0] exp_ea, input logic exp_bad);
        @(negedge clk);
        instr_word = w; disp_word = dsp; instr_addr = ip; base_val = bv; index_val = iv;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R3 valid"}, {31'b0, out_valid}, 32'd1);
        chk({tag, " addr"}, ea_out, exp_ea);
        chk({tag, " bad"}, {31'b0, ea_bad}, {31'b0, exp_bad});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R1 ea_out", ea_out, 32'd0);
        chk("R1 ea_bad", {31'b0, ea_bad}, 32'd0);
    endtask

    task automatic t_selects;
        @(negedge clk);
        instr_word = long_w(5'd21, 5'd9, 4'd7, 3'd0, 2'd0, 5'd30);
        #1;
        chk("R2 data_sel", {27'b0, data_sel}, 32'd21);
        chk("R2 base_sel", {27'b0, base_sel}, 32'd9);
        chk("R2 index_sel", {27'b0, index_sel}, 32'd30);
    endtask

    task automatic t_short;
        run("R4 off", short_w(5'd1, 5'd2, 1'b0, 12'hABC), 32'h5555_0000, 32'h40, 32'h7000, 32'h9, 32'h0000_0ABC, 1'b0);
        run("R4 off+base", short_w(5'd1, 5'd2, 1'b1, 12'hFFF), 32'h5, 32'h40, 32'h1000_0000, 32'h9, 32'h1000_0FFF, 1'b0);
        run("R4 scale bits ignored", short_w(5'd0, 5'd3, 1'b1, 12'h3E0), 32'h5, 32'h40, 32'h100, 32'h9, 32'h0000_04E0, 1'b0);
        run("R12 short wrap", short_w(5'd0, 5'd3, 1'b1, 12'h010), 32'h0, 32'h0, 32'hFFFF_FFF8, 32'h0, 32'h0000_0008, 1'b0);
    endtask

    task automatic t_base_ip;
        run("R5 mode4", long_w(5'd1, 5'd2, 4'd4, 3'd0, 2'd0, 5'd3), 32'h77, 32'h40, 32'h1234_5678, 32'h9, 32'h1234_5678, 1'b0);
        run("R5 mode5", long_w(5'd1, 5'd2, 4'd5, 3'd0, 2'd0, 5'd3), 32'h100, 32'h2000, 32'hAAAA, 32'h9, 32'h0000_2108, 1'b0);
        run("R12 mode5 wrap", long_w(5'd1, 5'd2, 4'd5, 3'd0, 2'd0, 5'd3), 32'h0, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0000_0004, 1'b0);
    endtask

    task automatic t_index;
        for (int s = 0; s < 5; s++) begin
            run("R6 mode7 scale", long_w(5'd1, 5'd2, 4'd7, 3'(s), 2'd0, 5'd3), 32'h999, 32'h40,
                32'h100, 32'd3, 32'h100 + (32'd3 << s), 1'b0);
        end
    endtask

    task automatic t_disp;
        run("R7 mode12", long_w(5'd1, 5'd2, 4'd12, 3'd0, 2'd0, 5'd3), 32'hDEAD_BEEF, 32'h40, 32'h100, 32'h9, 32'hDEAD_BEEF, 1'b0);
        run("R7 mode13", long_w(5'd1, 5'd2, 4'd13, 3'd0, 2'd0, 5'd3), 32'h1000, 32'h40, 32'h234, 32'h9, 32'h0000_1234, 1'b0);
        run("R8 mode14", long_w(5'd1, 5'd2, 4'd14, 3'd3, 2'd0, 5'd3), 32'h1000, 32'h40, 32'h234, 32'h5, 32'h0000_1028, 1'b0);
        run("R8 mode15", long_w(5'd1, 5'd2, 4'd15, 3'd4, 2'd0, 5'd3), 32'h1000, 32'h40, 32'h200, 32'h2, 32'h0000_1220, 1'b0);
        run("R12 mode15 wrap", long_w(5'd1, 5'd2, 4'd15, 3'd1, 2'd0, 5'd3), 32'hFFFF_FF00, 32'h40, 32'h80, 32'h40, 32'h0000_0000, 1'b0);
    endtask

    task automatic t_illegal;
        run("R10 mode6", long_w(5'd1, 5'd2, 4'd6, 3'd0, 2'd0, 5'd3), 32'h1000, 32'h40, 32'h200, 32'h2, 32'h0, 1'b1);
        run("R9 mode7 scale5", long_w(5'd1, 5'd2, 4'd7, 3'd5, 2'd0, 5'd3), 32'h1000, 32'h40, 32'h200, 32'h2, 32'h0, 1'b1);
        run("R9 mode12 scale7", long_w(5'd1, 5'd2, 4'd12, 3'd7, 2'd0, 5'd3), 32'h1000, 32'h40, 32'h200, 32'h2, 32'h0, 1'b1);
        run("R10 mode4 bits6:5=01", long_w(5'd1, 5'd2, 4'd4, 3'd0, 2'd1, 5'd3), 32'h1000, 32'h40, 32'h200, 32'h2, 32'h0, 1'b1);
        run("R11 mode13 bits6:5=10", long_w(5'd1, 5'd2, 4'd13, 3'd0, 2'd2, 5'd3), 32'h1000, 32'h40, 32'h200, 32'h2, 32'h0, 1'b1);
        run("R11 recover", long_w(5'd1, 5'd2, 4'd13, 3'd0, 2'd0, 5'd3), 32'h1000, 32'h40, 32'h200, 32'h2, 32'h0000_1200, 1'b0);
    endtask

    task automatic t_hold;
        @(negedge clk);
        instr_word = long_w(5'd1, 5'd2, 4'd6, 3'd0, 2'd0, 5'd3);
        base_val = 32'hFFFF_0000; disp_word = 32'h1;
        @(negedge clk);
        chk("R3 out_valid low", {31'b0, out_valid}, 32'd0);
        chk("R3 hold addr", ea_out, 32'h0000_1200);
        chk("R3 hold bad", {31'b0, ea_bad}, 32'd0);
    endtask

    initial begin
        t_reset;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_selects;
        t_short;
        t_base_ip;
        t_index;
        t_disp;
        t_illegal;
        t_hold;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog R3 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule